// File: doc/BRIEF.md
# Iterative AES-128 Cipher Core

This block encrypts or decrypts one 128-bit block under a 128-bit key by running a single shared round datapath ten times. A one-cycle `start` strobe captures the data word, the key and the direction bit. The core then expands the key into all eleven round keys, held in a small register array. Next it applies the initial key whitening and iterates the round logic. The working state sits in a dedicated round register, and only the value from the final round is copied into the separate result register.

Both directions share the S-box lanes, the row-rotation network and the column mixer. The direction bit picks the forward or inverse variant of each step and the order in which round keys are read from the array. Forward and inverse S-box values are computed from the GF(2^8) inverse and the affine map, so no lookup table is written out. A completion pulse marks the cycle in which the result register changes.

Top module: `aes128_iter_core`

## Requirements
- R1: With `encrypt`=1, the core returns the standard AES-128 ciphertext. Byte 0 of the state (row 0, column 0) is `din[127:120]`, and bytes fill the state column by column. Key bytes are ordered the same way: key 000102..0f with data 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: With `encrypt`=0, the core applies the inverse cipher under the same key. The ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a with key 000102..0f gives 00112233..ff.
- R3: For any key and data, decrypting the encryption result with the same key returns the original data.
- R4: `done` is high for exactly one cycle. It rises 21 clock edges after the edge that accepts `start`, and `dout` takes the new result on that same edge.
- R5: A `start` that arrives while an operation is in progress is ignored. It does not change the result or the timing of the current operation, and it does not begin another operation afterwards.
- R6: After reset, `dout` is zero and `done` is low. `dout` keeps its value between completions.
- R7: `din`, `key` and `encrypt` are sampled only on the accepting edge. Changes to them during an operation have no effect on its result.
- R8: A `start` given while `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when the core is idle |
| encrypt | input | 1 | 1 = encrypt, 0 = decrypt, sampled with `start` |
| din | input | 128 | Plaintext or ciphertext block, sampled with `start` |
| key | input | 128 | Cipher key, sampled with `start` |
| dout | output | 128 | Result register |
| done | output | 1 | One-cycle pulse when `dout` updates |

## Verification
On every cycle, the assertions check four things: that `done` never lasts two cycles, that `dout` stays still whenever `done` is low, that the captured direction stays fixed while the core is busy, and that the round and key-schedule counters stay in range. The correctness of the cipher arithmetic, the byte ordering, the 21-edge latency, and the immunity to stray strobes and input changes in mid-operation can only be shown by the bench scenarios. Those scenarios use the two standard vectors in each direction, a round trip on random keys and data, noisy runs and a chained pair of operations.

// File: rtl/aes128_pkg.sv
package aes128_pkg;
  localparam int BLK_W   = 128;
  localparam int WORD_W  = 32;
  localparam int NBYTES  = BLK_W / 8;
  localparam int NWORDS  = BLK_W / WORD_W;
  localparam int NROUNDS = 10;
  localparam int RK_CNT  = NROUNDS + 1;
  localparam int RIDX_W  = $clog2(RK_CNT);

  typedef logic [BLK_W-1:0]  block_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [7:0]        byte_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  localparam ridx_t LAST_IDX = ridx_t'(NROUNDS);

  typedef enum logic [1:0] {PH_IDLE, PH_EXPAND, PH_ROUND} phase_e;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gmul(byte_t a, byte_t b);
    byte_t p;
    byte_t x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // a^254 is the multiplicative inverse; zero maps to zero
  function automatic byte_t ginv(byte_t a);
    byte_t r;
    byte_t sq;
    logic [7:0] e;
    r  = 8'h01;
    sq = a;
    e  = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gmul(r, sq);
      sq = gmul(sq, sq);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(byte_t x, int n);
    return byte_t'((x << n) | (x >> (8 - n)));
  endfunction

  function automatic byte_t sbox_fwd(byte_t a);
    byte_t b;
    b = ginv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic byte_t sbox_inv(byte_t s);
    byte_t b;
    b = rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
    return ginv(b);
  endfunction

  // round constant for key-schedule step n (1..NROUNDS)
  function automatic byte_t rcon(ridx_t n);
    byte_t r;
    r = 8'h01;
    for (int i = 1; i < NROUNDS; i++) begin
      if (i < int'(n)) r = xtime(r);
    end
    return r;
  endfunction

  // state byte i = row (i%4), column (i/4); byte 0 in the top bits
  function automatic block_t shift_rows(block_t s, logic inv);
    block_t o;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        int src;
        src = inv ? ((c - r + 4) % 4) : ((c + r) % 4);
        o[BLK_W-1-8*(4*c+r) -: 8] = s[BLK_W-1-8*(4*src+r) -: 8];
      end
    end
    return o;
  endfunction

  function automatic word_t mix_col(word_t w, logic inv);
    byte_t a [4];
    byte_t k [4];
    word_t o;
    byte_t acc;
    o = '0;
    for (int j = 0; j < 4; j++) a[j] = w[31-8*j -: 8];
    if (inv) begin
      k[0] = 8'h0e; k[1] = 8'h0b; k[2] = 8'h0d; k[3] = 8'h09;
    end else begin
      k[0] = 8'h02; k[1] = 8'h03; k[2] = 8'h01; k[3] = 8'h01;
    end
    for (int r = 0; r < 4; r++) begin
      acc = '0;
      for (int j = 0; j < 4; j++) acc = acc ^ gmul(k[(j - r + 4) % 4], a[j]);
      o[31-8*r -: 8] = acc;
    end
    return o;
  endfunction

  function automatic block_t mix_cols(block_t s, logic inv);
    block_t o;
    for (int c = 0; c < NWORDS; c++)
      o[BLK_W-1-WORD_W*c -: WORD_W] = mix_col(s[BLK_W-1-WORD_W*c -: WORD_W], inv);
    return o;
  endfunction
endpackage

// File: rtl/aes128_sub_lanes.sv
module aes128_sub_lanes
  import aes128_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [8*LANES-1:0] bytes_i,
  input  logic               inv_i,
  output logic [8*LANES-1:0] bytes_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bytes_o[8*g +: 8] = inv_i ? sbox_inv(bytes_i[8*g +: 8])
                                     : sbox_fwd(bytes_i[8*g +: 8]);
  end
endmodule

// File: rtl/aes128_round.sv
module aes128_round
  import aes128_pkg::*;
(
  input  block_t state_i,
  input  block_t rkey_i,
  input  logic   enc_i,
  input  logic   last_i,
  output block_t state_o
);
  block_t sub_s;
  block_t rot_s;
  block_t keyed;
  block_t mixed;

  aes128_sub_lanes #(.LANES(NBYTES)) u_sub (
    .bytes_i (state_i),
    .inv_i   (!enc_i),
    .bytes_o (sub_s)
  );

  always_comb begin
    rot_s = shift_rows(sub_s, !enc_i);
    if (enc_i) begin
      // forward: substitute, rotate rows, mix (except last), add key
      mixed   = last_i ? rot_s : mix_cols(rot_s, 1'b0);
      keyed   = mixed ^ rkey_i;
      state_o = keyed;
    end else begin
      // inverse: unrotate, unsubstitute, add key, unmix (except last)
      keyed   = rot_s ^ rkey_i;
      mixed   = last_i ? keyed : mix_cols(keyed, 1'b1);
      state_o = mixed;
    end
  end
endmodule

// File: rtl/aes128_key_sched.sv
module aes128_key_sched
  import aes128_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   go_i,
  input  block_t key_i,
  input  ridx_t  rd_idx_i,
  output block_t rd_key_o,
  output logic   ready_o
);
  block_t rk_mem [RK_CNT];
  block_t cur_q;
  ridx_t  cnt_q;
  logic   active_q;

  word_t  w0, w1, w2, w3, rot_w, sub_w, tmp_w, n0, n1, n2, n3;
  block_t nxt;
  logic   wr_en;
  ridx_t  wr_idx;
  block_t wr_data;

  assign w0    = cur_q[BLK_W-1 -: WORD_W];
  assign w1    = cur_q[BLK_W-1-WORD_W -: WORD_W];
  assign w2    = cur_q[BLK_W-1-2*WORD_W -: WORD_W];
  assign w3    = cur_q[WORD_W-1:0];
  assign rot_w = {w3[23:0], w3[31:24]};

  aes128_sub_lanes #(.LANES(NWORDS)) u_subw (
    .bytes_i (rot_w),
    .inv_i   (1'b0),
    .bytes_o (sub_w)
  );

  assign tmp_w = sub_w ^ {rcon(cnt_q), 24'h000000};
  assign n0    = w0 ^ tmp_w;
  assign n1    = w1 ^ n0;
  assign n2    = w2 ^ n1;
  assign n3    = w3 ^ n2;
  assign nxt   = {n0, n1, n2, n3};

  assign wr_en   = go_i | active_q;
  assign wr_idx  = go_i ? '0 : cnt_q;
  assign wr_data = go_i ? key_i : nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      cur_q    <= '0;
      ready_o  <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        cnt_q    <= ridx_t'(1);
        cur_q    <= key_i;
      end else if (active_q) begin
        cur_q <= nxt;
        cnt_q <= cnt_q + ridx_t'(1);
        if (cnt_q == LAST_IDX) begin
          active_q <= 1'b0;
          ready_o  <= 1'b1;
        end
      end
    end
  end

  // round-key array: one write and one read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) rk_mem[wr_idx] <= wr_data;
  end

  assign rd_key_o = rk_mem[rd_idx_i];

  // R4: schedule completion is a single-cycle event
  a_r4_key_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  // R4: step counter stays within the schedule while running
  a_r4_key_step_range: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q >= ridx_t'(1) && cnt_q <= LAST_IDX));
endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
  import aes128_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         encrypt,
  input  logic [127:0] din,
  input  logic [127:0] key,
  output logic [127:0] dout,
  output logic         done
);
  phase_e ph_q;
  logic   enc_q;
  block_t st_q;
  ridx_t  rnd_q;

  logic   accept;
  logic   kready;
  ridx_t  rd_idx;
  block_t rkey;
  block_t rnd_out;

  assign accept = start && (ph_q == PH_IDLE);
  // round 0 reads key 0 (enc) or key 10 (dec); later rounds walk in opposite directions
  assign rd_idx = enc_q ? rnd_q : (LAST_IDX - rnd_q);

  aes128_key_sched u_keys (
    .clk      (clk),
    .rst      (rst),
    .go_i     (accept),
    .key_i    (key),
    .rd_idx_i (rd_idx),
    .rd_key_o (rkey),
    .ready_o  (kready)
  );

  aes128_round u_round (
    .state_i (st_q),
    .rkey_i  (rkey),
    .enc_i   (enc_q),
    .last_i  (rnd_q == LAST_IDX),
    .state_o (rnd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      enc_q <= 1'b0;
      st_q  <= '0;
      rnd_q <= '0;
      dout  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            st_q  <= din;
            enc_q <= encrypt;
            rnd_q <= '0;
            ph_q  <= PH_EXPAND;
          end
        end
        PH_EXPAND: begin
          if (kready) begin
            st_q  <= st_q ^ rkey;
            rnd_q <= ridx_t'(1);
            ph_q  <= PH_ROUND;
          end
        end
        PH_ROUND: begin
          st_q <= rnd_out;
          if (rnd_q == LAST_IDX) begin
            dout <= rnd_out;
            done <= 1'b1;
            ph_q <= PH_IDLE;
          end else begin
            rnd_q <= rnd_q + ridx_t'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R4: completion pulse never lasts two cycles
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: result register only moves together with the completion pulse
  a_r6_dout_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dout));

  // R7: captured direction is frozen while an operation runs
  a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE) |=> $stable(enc_q));

  // R4: round counter stays in 1..10 during the round phase
  a_r4_round_range: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ROUND) |-> (rnd_q >= ridx_t'(1) && rnd_q <= LAST_IDX));
endmodule

// File: tb/aes128_iter_core_test.sv
module aes128_iter_core_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         encrypt = 1'b0;
  logic [127:0] din = '0;
  logic [127:0] key = '0;
  logic [127:0] dout;
  logic         done;

  int checks = 0;
  int errors = 0;
  localparam int EXP_LAT = 21;

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;

  aes128_iter_core uut (
    .clk(clk), .rst(rst), .start(start), .encrypt(encrypt),
    .din(din), .key(key), .dout(dout), .done(done)
  );

  always #5 clk = ~clk;

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the negedge where done is seen
  task automatic run_op(input logic enc, input logic [127:0] d, input logic [127:0] k,
                        input logic noisy, output logic [127:0] res, output int lat);
    start = 1'b1; encrypt = enc; din = d; key = k;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (noisy) begin
        start = 1'b1; encrypt = logic'($urandom); din = rnd128(); key = rnd128();
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
      if (lat > 200) begin
        $display("FAIL R4 actual=no-done expected=done");
        errors++;
        break;
      end
    end
    start = 1'b0;
    res = dout;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [127:0] r, r2, hold, pt, ct;
  int lat, lat2, extra;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R6: reset state
    chk("R6 reset dout", dout, '0);
    chk("R6 reset done", {127'd0, done}, '0);

    // R1 / R4: first vector encrypt, latency and single-cycle pulse
    run_op(1'b1, P1, K1, 1'b0, r, lat);
    chk("R1 encrypt vec1", r, C1);
    chk("R4 latency", lat, EXP_LAT);
    @(negedge clk);
    chk("R4 done one cycle", {127'd0, done}, '0);

    run_op(1'b1, P2, K2, 1'b0, r, lat);
    chk("R1 encrypt vec2", r, C2);
    @(negedge clk);

    // R2: decryption of both vectors
    run_op(1'b0, C1, K1, 1'b0, r, lat);
    chk("R2 decrypt vec1", r, P1);
    chk("R4 latency decrypt", lat, EXP_LAT);
    @(negedge clk);
    run_op(1'b0, C2, K2, 1'b0, r, lat);
    chk("R2 decrypt vec2", r, P2);

    // R6: dout holds while idle with changing inputs
    hold = dout;
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      din = rnd128(); key = rnd128(); encrypt = logic'($urandom);
      @(negedge clk);
      if (done) extra++;
    end
    chk("R6 dout hold", dout, hold);
    chk("R6 no spurious done", extra, 0);

    // R5 / R7: strobes and input changes during a run are ignored
    run_op(1'b1, P1, K1, 1'b1, r, lat);
    chk("R7 noisy encrypt result", r, C1);
    chk("R5 noisy latency", lat, EXP_LAT);
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R5 no extra operation", extra, 0);
    chk("R5 dout kept", dout, C1);

    run_op(1'b0, C2, K2, 1'b1, r, lat);
    chk("R7 noisy decrypt result", r, P2);

    // R8: back-to-back, second start given while done is high
    @(negedge clk);
    run_op(1'b1, P2, K2, 1'b0, r, lat);
    run_op(1'b0, C1, K1, 1'b0, r2, lat2);
    chk("R8 chained first", r, C2);
    chk("R8 chained second", r2, P1);
    chk("R8 chained latency", lat2, EXP_LAT);

    // R3: random round trips, alternating noisy runs
    for (int n = 0; n < 12; n++) begin
      logic [127:0] kk;
      kk = rnd128();
      pt = rnd128();
      @(negedge clk);
      run_op(1'b1, pt, kk, logic'(n[0]), ct, lat);
      @(negedge clk);
      run_op(1'b0, ct, kk, logic'(n[1]), r, lat);
      chk("R3 round trip", r, pt);
      @(negedge clk);
      run_op(1'b1, pt, kk, 1'b0, r, lat);
      chk("R3 repeat encrypt", r, ct);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule